// File: doc/BRIEF.md
# Receive Byte Lane Order Aligner

This block sits on a two-lane receive path whose words are already aligned. Each clock carries two bytes, and each byte has its own control/data flag. Lane 0 is the least significant byte. The block watches for a configured ordering byte. It makes sure that, once it has acted, the ordering byte is in lane 0 of an output word. When the ordering byte arrives in lane 1, the block puts one pad character into the stream. A one-byte holding register then delays every later byte by one lane position, so the ordering byte and the bytes after it come out in stream order from lane 0 upward.

Two arming sources are available. In sync-status mode, reordering happens once: only the first ordering byte seen while the sync-status input is high has any effect. After that, a sticky flag blocks further reordering until the digital reset is applied. In dynamic mode, a user-logic enable arms the block. Every ordering byte seen while that enable is high triggers a fresh reorder.

The output is registered, with one cycle of latency. Words that are not valid come out as pad characters in both lanes. A one-cycle pulse marks the output word that carries a reorder, and a sticky flag records that a reorder has happened.

Top module: `rx_lane_order_aligner`

## Requirements
- R1: A byte matches only when its 8-bit value equals `cfg_pattern` and its control flag equals `cfg_pattern_ctrl`. If both lanes match, lane 0 takes priority.
- R2: On a reorder where the match is in lane 0, the input word passes to the output unchanged, and the block leaves the shifted state.
- R3: On a reorder where the match is in lane 1, the output word is {lane 1 = pad, lane 0 = input lane 0}. The pad uses `cfg_pad_ctrl` as its flag. The matched byte is held and appears in lane 0 of the next valid output word.
- R4: In the shifted state, every valid output word is {lane 1 = current input lane 0, lane 0 = held byte}, and input lane 1 becomes the new held byte. This state lasts until the next reorder or a reset. Invalid cycles leave the held byte untouched.
- R5: With `mode_dyn`=0, the block is armed only while `sync_ok`=1 and no reorder has yet happened. After the first reorder, later ordering bytes have no effect on data, the pulse or the shift state until reset.
- R6: With `mode_dyn`=1, every match on a valid word reorders while `order_req`=1. No match reorders while `order_req`=0.
- R7: `order_pulse` is high for exactly the one output word produced by a reorder.
- R8: `order_done` goes high with the first reorder pulse and stays high until reset.
- R9: `out_valid` follows `in_valid` one cycle later. A non-valid output word has the pad value and the pad flag in both lanes.
- R10: While `dig_rst` is high, the outputs are invalid pad words, the pulse and `order_done` are low, and the shift state and holding byte are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| dig_rst | input | 1 | Synchronous digital reset, active high |
| in_valid | input | 1 | Input word qualifier |
| in_data | input | 16 | Input bytes, lane 0 in bits 7:0 |
| in_ctrl | input | 2 | Per-lane control/data flag, bit i for lane i |
| mode_dyn | input | 1 | 0 = arm from sync status, 1 = arm from `order_req` |
| sync_ok | input | 1 | Receive sync status from the aligner upstream |
| order_req | input | 1 | Dynamic reorder enable from user logic |
| cfg_pattern | input | 8 | Ordering byte value |
| cfg_pattern_ctrl | input | 1 | Ordering byte control flag |
| cfg_pad | input | 8 | Pad character value |
| cfg_pad_ctrl | input | 1 | Pad character control flag |
| out_valid | output | 1 | Output word qualifier |
| out_data | output | 16 | Reordered bytes, lane 0 in bits 7:0 |
| out_ctrl | output | 2 | Reordered per-lane control flags |
| order_pulse | output | 1 | One-cycle marker of a reorder word |
| order_done | output | 1 | Sticky reorder-happened flag |

## Verification
The assertions assume that `mode_dyn` and the four configuration inputs stay constant between resets. They check the idle pad value and the one-shot rule against the current configuration and mode, so those inputs must not change while the block is running. The stimulus sets the mode and the configuration only before it raises `dig_rst`. It sweeps every combination of mode, match lane (lane 0, lane 1, both) and pad character, with a fixed sequence of disarmed matches, flag mismatches, idle cycles and repeated matches.

// File: rtl/rx_order_pkg.sv
package rx_order_pkg;

    // Number of byte lanes per word; the shift logic covers a one-lane offset
    localparam int LANES = 2;

    typedef enum logic [1:0] {
        HIT_NONE  = 2'd0,
        HIT_LANE0 = 2'd1,
        HIT_LANE1 = 2'd2
    } hit_e;

endpackage

// File: rtl/rx_order_detect.sv
module rx_order_detect
    import rx_order_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [LANES*DATA_W-1:0] word_data,
    input  logic [LANES-1:0]        word_ctrl,
    input  logic                    word_valid,
    input  logic [DATA_W-1:0]       pattern,
    input  logic                    pattern_ctrl,
    output hit_e                    hit
);

    logic [LANES-1:0] lane_match;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_match[g] = word_valid
                             && (word_data[g*DATA_W +: DATA_W] == pattern)
                             && (word_ctrl[g] == pattern_ctrl);
    end

    // lane 0 has priority when both lanes carry the ordering byte
    always_comb begin
        if (lane_match[0]) begin
            hit = HIT_LANE0;
        end else if (lane_match[1]) begin
            hit = HIT_LANE1;
        end else begin
            hit = HIT_NONE;
        end
    end

endmodule

// File: rtl/rx_order_arm.sv
module rx_order_arm (
    input  logic mode_dyn,
    input  logic sync_ok,
    input  logic order_req,
    input  logic done,
    output logic armed
);

    // sync-status mode acts once; dynamic mode follows the user enable
    always_comb begin
        if (mode_dyn) begin
            armed = order_req;
        end else begin
            armed = sync_ok && !done;
        end
    end

endmodule

// File: rtl/rx_lane_order_aligner.sv
module rx_lane_order_aligner
    import rx_order_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                    clk,
    input  logic                    dig_rst,
    input  logic                    in_valid,
    input  logic [2*DATA_W-1:0]     in_data,
    input  logic [1:0]              in_ctrl,
    input  logic                    mode_dyn,
    input  logic                    sync_ok,
    input  logic                    order_req,
    input  logic [DATA_W-1:0]       cfg_pattern,
    input  logic                    cfg_pattern_ctrl,
    input  logic [DATA_W-1:0]       cfg_pad,
    input  logic                    cfg_pad_ctrl,
    output logic                    out_valid,
    output logic [2*DATA_W-1:0]     out_data,
    output logic [1:0]              out_ctrl,
    output logic                    order_pulse,
    output logic                    order_done
);

    localparam int WORD_W = LANES * DATA_W;

    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic [LANES-1:0]  ctrl;
        logic              valid;
        logic              pulse;
        logic              done;
        logic              shifted;
        logic [DATA_W-1:0] hold_data;
        logic              hold_ctrl;
    } state_t;

    state_t st_d, st_q;
    hit_e   hit;
    logic   armed;

    logic [DATA_W-1:0] lane0_d, lane1_d;
    assign lane0_d = in_data[DATA_W-1:0];
    assign lane1_d = in_data[WORD_W-1 -: DATA_W];

    rx_order_detect #(.DATA_W(DATA_W)) i_detect (
        .word_data    (in_data),
        .word_ctrl    (in_ctrl),
        .word_valid   (in_valid),
        .pattern      (cfg_pattern),
        .pattern_ctrl (cfg_pattern_ctrl),
        .hit          (hit)
    );

    rx_order_arm i_arm (
        .mode_dyn  (mode_dyn),
        .sync_ok   (sync_ok),
        .order_req (order_req),
        .done      (st_q.done),
        .armed     (armed)
    );

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        if (!in_valid) begin
            st_d.valid = 1'b0;
            st_d.data  = {LANES{cfg_pad}};
            st_d.ctrl  = {LANES{cfg_pad_ctrl}};
        end else begin
            st_d.valid = 1'b1;
            if (armed && hit == HIT_LANE0) begin
                st_d.data    = in_data;
                st_d.ctrl    = in_ctrl;
                st_d.shifted = 1'b0;
                st_d.pulse   = 1'b1;
                st_d.done    = 1'b1;
            end else if (armed && hit == HIT_LANE1) begin
                st_d.data      = {cfg_pad, lane0_d};
                st_d.ctrl      = {cfg_pad_ctrl, in_ctrl[0]};
                st_d.hold_data = lane1_d;
                st_d.hold_ctrl = in_ctrl[1];
                st_d.shifted   = 1'b1;
                st_d.pulse     = 1'b1;
                st_d.done      = 1'b1;
            end else if (st_q.shifted) begin
                st_d.data      = {lane0_d, st_q.hold_data};
                st_d.ctrl      = {in_ctrl[0], st_q.hold_ctrl};
                st_d.hold_data = lane1_d;
                st_d.hold_ctrl = in_ctrl[1];
            end else begin
                st_d.data = in_data;
                st_d.ctrl = in_ctrl;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (dig_rst) begin
            st_q.data      <= {LANES{cfg_pad}};
            st_q.ctrl      <= {LANES{cfg_pad_ctrl}};
            st_q.valid     <= 1'b0;
            st_q.pulse     <= 1'b0;
            st_q.done      <= 1'b0;
            st_q.shifted   <= 1'b0;
            st_q.hold_data <= '0;
            st_q.hold_ctrl <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid   = st_q.valid;
    assign out_data    = st_q.data;
    assign out_ctrl    = st_q.ctrl;
    assign order_pulse = st_q.pulse;
    assign order_done  = st_q.done;

endmodule

// File: rtl/rx_lane_order_aligner_chk.sv
module rx_lane_order_aligner_chk #(
    parameter int DATA_W = 8
) (
    input logic                clk,
    input logic                dig_rst,
    input logic                mode_dyn,
    input logic [DATA_W-1:0]   cfg_pattern,
    input logic                cfg_pattern_ctrl,
    input logic [DATA_W-1:0]   cfg_pad,
    input logic                cfg_pad_ctrl,
    input logic                out_valid,
    input logic [2*DATA_W-1:0] out_data,
    input logic [1:0]          out_ctrl,
    input logic                order_pulse,
    input logic                order_done
);

    // R7
    pulse_on_valid_chk: assert property (@(posedge clk) disable iff (dig_rst)
        order_pulse |-> out_valid);

    // R8
    done_sticky_chk: assert property (@(posedge clk) disable iff (dig_rst)
        order_done |=> order_done);

    // R8
    pulse_sets_done_chk: assert property (@(posedge clk) disable iff (dig_rst)
        order_pulse |-> order_done);

    // R5
    one_shot_chk: assert property (@(posedge clk) disable iff (dig_rst)
        (!mode_dyn && order_done) |=> !order_pulse);

    // R9
    idle_pad_chk: assert property (@(posedge clk) disable iff (dig_rst)
        !out_valid |-> (out_data == {2{cfg_pad}} && out_ctrl == {2{cfg_pad_ctrl}}));

    // R3
    reorder_word_chk: assert property (@(posedge clk) disable iff (dig_rst)
        order_pulse |-> ((out_data[DATA_W-1:0] == cfg_pattern && out_ctrl[0] == cfg_pattern_ctrl)
                      || (out_data[2*DATA_W-1 -: DATA_W] == cfg_pad && out_ctrl[1] == cfg_pad_ctrl)));

endmodule

bind rx_lane_order_aligner rx_lane_order_aligner_chk #(.DATA_W(DATA_W)) i_chk (
    .clk              (clk),
    .dig_rst          (dig_rst),
    .mode_dyn         (mode_dyn),
    .cfg_pattern      (cfg_pattern),
    .cfg_pattern_ctrl (cfg_pattern_ctrl),
    .cfg_pad          (cfg_pad),
    .cfg_pad_ctrl     (cfg_pad_ctrl),
    .out_valid        (out_valid),
    .out_data         (out_data),
    .out_ctrl         (out_ctrl),
    .order_pulse      (order_pulse),
    .order_done       (order_done)
);

// File: tb/test_rx_lane_order_aligner.sv
module test_rx_lane_order_aligner;

    localparam logic [7:0] PAT = 8'hBC;

    logic        clk = 1'b0;
    logic        dig_rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [15:0] in_data = '0;
    logic [1:0]  in_ctrl = '0;
    logic        mode_dyn = 1'b0;
    logic        sync_ok = 1'b0;
    logic        order_req = 1'b0;
    logic [7:0]  cfg_pattern = PAT;
    logic        cfg_pattern_ctrl = 1'b1;
    logic [7:0]  cfg_pad = '0;
    logic        cfg_pad_ctrl = 1'b0;
    logic        out_valid;
    logic [15:0] out_data;
    logic [1:0]  out_ctrl;
    logic        order_pulse;
    logic        order_done;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 0;

    // bench-side expectation state, derived from the requirements
    bit         m_shift, m_done;
    logic [7:0] m_hold_d;
    logic       m_hold_c;
    int         seq;

    always #5 clk = ~clk;

    rx_lane_order_aligner #(.DATA_W(8)) i_rx_lane_order_aligner (
        .clk(clk), .dig_rst(dig_rst), .in_valid(in_valid), .in_data(in_data),
        .in_ctrl(in_ctrl), .mode_dyn(mode_dyn), .sync_ok(sync_ok),
        .order_req(order_req), .cfg_pattern(cfg_pattern),
        .cfg_pattern_ctrl(cfg_pattern_ctrl), .cfg_pad(cfg_pad),
        .cfg_pad_ctrl(cfg_pad_ctrl), .out_valid(out_valid), .out_data(out_data),
        .out_ctrl(out_ctrl), .order_pulse(order_pulse), .order_done(order_done)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h (seq %0d)", tag, act, exp, seq);
        end
    endtask

    function automatic logic [7:0] plain(input int k);
        return 8'((k * 7 + 3) & 255);
    endfunction

    // drive one word at a negedge, check the registered result one cycle later
    task automatic apply(input bit v, input logic [7:0] d0, input bit c0,
                         input logic [7:0] d1, input bit c1, input bit arm_in,
                         input string tag);
        bit hit0, hit1, arm, ev;
        logic [15:0] e_d;
        logic [1:0]  e_c;
        bit e_p;
        in_valid  = v;
        in_data   = {d1, d0};
        in_ctrl   = {c1, c0};
        sync_ok   = arm_in;
        order_req = arm_in;
        hit0 = v && d0 == PAT && c0 == cfg_pattern_ctrl;
        hit1 = v && d1 == PAT && c1 == cfg_pattern_ctrl;
        arm  = mode_dyn ? arm_in : (arm_in && !m_done);
        ev   = arm && (hit0 || hit1);
        e_p  = 1'b0;
        if (!v) begin
            e_d = {cfg_pad, cfg_pad};
            e_c = {cfg_pad_ctrl, cfg_pad_ctrl};
        end else if (ev && hit0) begin
            e_d = {d1, d0}; e_c = {c1, c0};
            m_shift = 0; m_done = 1; e_p = 1;
        end else if (ev) begin
            e_d = {cfg_pad, d0}; e_c = {cfg_pad_ctrl, c0};
            m_hold_d = d1; m_hold_c = c1; m_shift = 1; m_done = 1; e_p = 1;
        end else if (m_shift) begin
            e_d = {d0, m_hold_d}; e_c = {c0, m_hold_c};
            m_hold_d = d1; m_hold_c = c1;
        end else begin
            e_d = {d1, d0}; e_c = {c1, c0};
        end
        @(negedge clk);
        seq++;
        check("R9 valid", 32'(out_valid), 32'(v));
        check({tag, " data"}, 32'(out_data), 32'(e_d));
        check({tag, " ctrl"}, 32'(out_ctrl), 32'(e_c));
        check("R7 pulse", 32'(order_pulse), 32'(e_p));
        check("R8 done", 32'(order_done), 32'(m_done));
    endtask

    task automatic run_case(input bit mode, input int pos, input logic [7:0] pad, input bit padc);
        int k;
        mode_dyn = mode; cfg_pad = pad; cfg_pad_ctrl = padc;
        in_valid = 0; sync_ok = 0; order_req = 0;
        dig_rst = 1;
        @(negedge clk); @(negedge clk);
        // R10 reset state
        check("R10 valid", 32'(out_valid), 32'd0);
        check("R10 data", 32'(out_data), 32'({pad, pad}));
        check("R10 ctrl", 32'(out_ctrl), 32'({padc, padc}));
        check("R10 pulse", 32'(order_pulse), 32'd0);
        check("R10 done", 32'(order_done), 32'd0);
        dig_rst = 0;
        m_shift = 0; m_done = 0; m_hold_d = '0; m_hold_c = 0;
        k = 0;
        // disarmed match is ignored (R5 sync low / R6 request low)
        apply(1, PAT, 1, plain(k), 0, 0, mode ? "R6 disarmed" : "R5 sync low"); k++;
        // value matches but control flag differs
        apply(1, plain(k), 0, PAT, 0, 1, "R1 flag mismatch"); k++;
        apply(1, plain(k), 0, plain(k + 50), 0, 1, "R2 passthrough"); k++;
        // the first ordering byte
        case (pos)
            0: apply(1, PAT, 1, plain(k), 0, 1, "R2 lane0 hit");
            1: apply(1, plain(k), 0, PAT, 1, 1, "R3 lane1 hit");
            default: apply(1, PAT, 1, PAT, 1, 1, "R1 both lanes");
        endcase
        k++;
        apply(1, plain(k), 0, plain(k + 50), 1, 1, "R3 after hit"); k++;
        apply(0, plain(k), 1, plain(k), 1, 1, "R9 idle");
        apply(1, plain(k), 1, plain(k + 50), 0, 1, "R4 hold kept"); k++;
        // a second ordering byte, lane 0
        apply(1, PAT, 1, plain(k), 0, 1, mode ? "R6 repeat lane0" : "R5 ignored lane0"); k++;
        apply(1, plain(k), 0, plain(k + 50), 0, 1, "R4 steady"); k++;
        apply(1, plain(k), 1, plain(k + 50), 0, 1, "R4 steady"); k++;
        // a third ordering byte, lane 1
        apply(1, plain(k), 0, PAT, 1, 1, mode ? "R6 repeat lane1" : "R5 ignored lane1"); k++;
        apply(1, plain(k), 0, plain(k + 50), 1, 1, "R4 shifted"); k++;
        apply(1, PAT, 1, plain(k), 0, 0, mode ? "R6 request low" : "R5 sync low"); k++;
        apply(1, plain(k), 0, plain(k + 50), 0, 1, "R4 tail");
    endtask

    initial begin
        logic [7:0] pads [4];
        bit         padcs [4];
        pads[0] = 8'hF7; padcs[0] = 1;
        pads[1] = 8'h00; padcs[1] = 0;
        pads[2] = 8'h1C; padcs[2] = 1;
        pads[3] = 8'hBC; padcs[3] = 0;
        seq = 0;
        @(negedge clk);
        for (int m = 0; m < 2; m++) begin
            for (int p = 0; p < 3; p++) begin
                for (int q = 0; q < 4; q++) begin
                    run_case(m[0], p, pads[q], padcs[q]);
                end
            end
        end
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            miscompares++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule